// File: doc/BRIEF.md
# Next-Instruction Priority Dispatch Encoder

At the boundary between two instructions, the sequencer must decide where control goes next. The decision can be the second half of an interrupt, the halt loop, a meter service, a new interrupt, a trace hook, a trap, an instruction that comes from the accumulator file, or normal execution. This block makes that choice. On a dispatch request it ranks the pending conditions in a fixed order. It then registers a 4-bit dispatch offset with a one-cycle valid strobe.

Trap conditions are held as sticky per-source flags inside the block. The flags are cleared when a trap dispatch is taken. A second rule governs timing. A request that arrives in the cycle directly after an instruction fetch request is held back by one cycle. This gives the accumulator-address indicator time to settle. The held request is then evaluated against the inputs of that later cycle.

Top module: `nid_dispatch`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `valid_o` is 0 and `offset_o` is 0, and no trap flag is pending.
- R2: An evaluated dispatch with `intr_cyc_i` high yields offset 0, whatever the other inputs are.
- R3: If R2 does not apply and `run_i` is low, the offset is 2 (halt loop).
- R4: If R2 and R3 do not apply and `meter_req_i` is high, the offset is 4.
- R5: If R2 to R4 do not apply and `intr_rdy_i` is high, the offset is 6.
- R6: If R2 to R5 do not apply and `trace_en_i` is high, the offset is 8.
- R7: If R2 to R6 do not apply and any trap flag is pending, the offset is 11. Taking this dispatch clears every pending flag.
- R8: If R2 to R7 do not apply and `ac_ref_i` is high, the offset is 14 (instruction read from the accumulator file).
- R9: If none of R2 to R8 applies, the offset is 10 (normal execute).
- R10: A dispatch is evaluated only in a cycle with an active request, using that cycle's inputs. `valid_o` is high for exactly the one cycle after the evaluation, and `offset_o` holds the result from then on.
- R11: A request in a cycle directly after a cycle with `fetch_i` high is not evaluated. It is evaluated in the next cycle, with that cycle's inputs. A request in the same cycle as `fetch_i` is not delayed.
- R12: A bit of `trap_set_i` that is high sets its flag from the next cycle on. A set that coincides with a trap dispatch stays pending after that dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_req_i | input | 1 | Request to evaluate the next dispatch |
| fetch_i | input | 1 | Instruction fetch request issued this cycle |
| intr_cyc_i | input | 1 | Interrupt cycle in progress |
| run_i | input | 1 | Run flag; low means halt |
| meter_req_i | input | 1 | Meter service request |
| intr_rdy_i | input | 1 | Interrupt request ready |
| trace_en_i | input | 1 | Tracing enabled |
| trap_set_i | input | NUM_TRAPS | Per-source trap flag set pulses |
| ac_ref_i | input | 1 | Next instruction address lies in the accumulator range |
| offset_o | output | 4 | Registered dispatch offset |
| valid_o | output | 1 | One-cycle strobe for a new offset |

## Verification
The assertions assume that the condition inputs hold stable levels for a whole cycle. They also assume that `fetch_i` is low while reset is applied, because the interlock check looks two cycles back. The bench changes every input only on the falling edge. It drives all inputs low during reset. It sweeps all 128 combinations of the seven ranked conditions, and it creates trap conditions only through `trap_set_i`. Before the next combination, it flushes any trap that a higher-priority condition left pending.

// File: rtl/nid_pkg.sv
package nid_pkg;
  localparam int OFF_W = 4;
  typedef logic [OFF_W-1:0] off_t;
  localparam off_t OFF_INTR_CYC = 4'd0;
  localparam off_t OFF_HALT     = 4'd2;
  localparam off_t OFF_METER    = 4'd4;
  localparam off_t OFF_INTR_NEW = 4'd6;
  localparam off_t OFF_TRACE    = 4'd8;
  localparam off_t OFF_EXEC     = 4'd10;
  localparam off_t OFF_TRAP     = 4'd11;
  localparam off_t OFF_AC_FETCH = 4'd14;
endpackage

// File: rtl/nid_fetch_gap.sv
module nid_fetch_gap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_i,
  input  logic req_i,
  output logic eval_o
);
  logic fetch_q, held_q, pend;

  assign pend   = req_i | held_q;
  assign eval_o = pend & ~fetch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      fetch_q <= fetch_i;
      held_q  <= pend & fetch_q;
    end
  end

  // a request blocked by a fetch is taken once the gap has passed
  p_held_taken_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && fetch_q && !fetch_i) |=> eval_o);
endmodule

// File: rtl/nid_trap_flags.sv
module nid_trap_flags #(
  parameter int NUM_TRAPS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TRAPS-1:0] set_i,
  input  logic                 clr_i,
  output logic                 any_o
);
  logic [NUM_TRAPS-1:0] flag_q;

  for (genvar g = 0; g < NUM_TRAPS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= (flag_q[g] & ~clr_i) | set_i[g];
    end
  end

  assign any_o = |flag_q;

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((flag_q & ~$past(set_i)) == '0));
  p_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> any_o);
endmodule

// File: rtl/nid_prio_enc.sv
module nid_prio_enc
  import nid_pkg::*;
(
  input  logic intr_cyc_i,
  input  logic run_i,
  input  logic meter_req_i,
  input  logic intr_rdy_i,
  input  logic trace_en_i,
  input  logic trap_i,
  input  logic ac_ref_i,
  output off_t sel_o,
  output logic is_trap_o
);
  always_comb begin
    is_trap_o = 1'b0;
    if (intr_cyc_i)       sel_o = OFF_INTR_CYC;
    else if (!run_i)      sel_o = OFF_HALT;
    else if (meter_req_i) sel_o = OFF_METER;
    else if (intr_rdy_i)  sel_o = OFF_INTR_NEW;
    else if (trace_en_i)  sel_o = OFF_TRACE;
    else if (trap_i) begin
      sel_o     = OFF_TRAP;
      is_trap_o = 1'b1;
    end
    else if (ac_ref_i)    sel_o = OFF_AC_FETCH;
    else                  sel_o = OFF_EXEC;
  end
endmodule

// File: rtl/nid_dispatch.sv
module nid_dispatch
  import nid_pkg::*;
#(
  parameter int NUM_TRAPS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disp_req_i,
  input  logic                 fetch_i,
  input  logic                 intr_cyc_i,
  input  logic                 run_i,
  input  logic                 meter_req_i,
  input  logic                 intr_rdy_i,
  input  logic                 trace_en_i,
  input  logic [NUM_TRAPS-1:0] trap_set_i,
  input  logic                 ac_ref_i,
  output logic [OFF_W-1:0]     offset_o,
  output logic                 valid_o
);
  logic eval, trap_any, sel_trap;
  off_t sel, offset_q;
  logic valid_q;

  nid_fetch_gap u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fetch_i (fetch_i),
    .req_i   (disp_req_i),
    .eval_o  (eval)
  );

  nid_trap_flags #(.NUM_TRAPS(NUM_TRAPS)) u_traps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trap_set_i),
    .clr_i  (eval & sel_trap),
    .any_o  (trap_any)
  );

  nid_prio_enc u_enc (
    .intr_cyc_i  (intr_cyc_i),
    .run_i       (run_i),
    .meter_req_i (meter_req_i),
    .intr_rdy_i  (intr_rdy_i),
    .trace_en_i  (trace_en_i),
    .trap_i      (trap_any),
    .ac_ref_i    (ac_ref_i),
    .sel_o       (sel),
    .is_trap_o   (sel_trap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      offset_q <= OFF_INTR_CYC;
    end else begin
      valid_q <= eval;
      if (eval) offset_q <= sel;
    end
  end

  assign valid_o  = valid_q;
  assign offset_o = offset_q;

  p_intr_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval && intr_cyc_i) |=> (valid_o && offset_o == OFF_INTR_CYC));
  p_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval && !intr_cyc_i && !run_i) |=> (offset_o == OFF_HALT));
  p_valid_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(disp_req_i)) |-> $past(disp_req_i, 2));
  p_fetch_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !$past(fetch_i, 2));
  p_offset_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(offset_o));
endmodule

// File: tb/tb_nid_dispatch.sv
module tb_nid_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic disp_req = 0, fetch = 0, intr_cyc = 0, run = 0, meter = 0, irdy = 0, trace = 0, ac = 0;
  logic [NT-1:0] tset = '0;
  logic [3:0] offset;
  logic valid;
  int total = 0, bad = 0, cyc = 0;
  bit model_trap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nid_dispatch #(.NUM_TRAPS(NT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .disp_req_i(disp_req), .fetch_i(fetch),
    .intr_cyc_i(intr_cyc), .run_i(run), .meter_req_i(meter), .intr_rdy_i(irdy),
    .trace_en_i(trace), .trap_set_i(tset), .ac_ref_i(ac),
    .offset_o(offset), .valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_off(input logic [6:0] v, input bit trp);
    // v = {intr_cyc, run, meter, irdy, trace, unused, ac}
    if (v[6]) return 0;
    if (!v[5]) return 2;
    if (v[4]) return 4;
    if (v[3]) return 6;
    if (v[2]) return 8;
    if (trp) return 11;
    if (v[0]) return 14;
    return 10;
  endfunction

  function automatic string tag(input int o);
    case (o)
      0: return "R2"; 2: return "R3"; 4: return "R4"; 6: return "R5";
      8: return "R6"; 11: return "R7"; 14: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic set_lv(input logic [6:0] v);
    intr_cyc = v[6]; run = v[5]; meter = v[4]; irdy = v[3]; trace = v[2]; ac = v[0];
  endtask

  // one request with current levels; checks result and strobe width (R10)
  task automatic do_disp(input int exp);
    disp_req = 1;
    @(negedge clk);
    disp_req = 0;
    chk("R10 valid", valid, 1);
    chk(tag(exp), offset, exp);
    @(negedge clk);
    chk("R10 one-cycle", valid, 0);
    chk("R10 hold", offset, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", valid, 0);
    chk("R1 offset", offset, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 valid after", valid, 0);
    // R1: no trap pending after reset -> normal execute
    run = 1;
    do_disp(10);

    for (int i = 0; i < 128; i++) begin
      logic [6:0] v = 7'(i);
      bit trp = v[1];
      int e;
      if (trp) begin
        tset = 3'(1 << (i % NT));
        @(negedge clk);
        tset = '0;
        model_trap = 1;
      end
      set_lv(v);
      e = exp_off(v, model_trap);
      do_disp(e);
      if (e == 11) model_trap = 0;
      if (model_trap) begin
        set_lv(7'b0100000);
        do_disp(11);  // R7 flush of leftover trap
        model_trap = 0;
      end
      set_lv(7'b0100000);
      if (trp) do_disp(10); // R7 flags cleared
    end

    // R12: set coinciding with trap dispatch stays pending
    set_lv(7'b0100000);
    tset = 3'b001;
    @(negedge clk);
    tset = 3'b100;
    disp_req = 1;
    @(negedge clk);
    disp_req = 0; tset = '0;
    chk("R12 first", offset, 11);
    @(negedge clk);
    do_disp(11);
    do_disp(10);

    // R11: request in cycle after fetch is delayed, uses later inputs
    set_lv(7'b0100000);
    fetch = 1;
    @(negedge clk);
    fetch = 0; disp_req = 1;
    @(negedge clk);
    disp_req = 0;
    chk("R11 delayed", valid, 0);
    meter = 1;
    @(negedge clk);
    chk("R11 valid later", valid, 1);
    chk("R11 later inputs", offset, 4);
    meter = 0;
    @(negedge clk);
    chk("R11 one-cycle", valid, 0);

    // R11: request together with fetch is not delayed
    fetch = 1; ac = 1; disp_req = 1;
    @(negedge clk);
    fetch = 0; disp_req = 0;
    chk("R11 same-cycle valid", valid, 1);
    chk("R11 same-cycle offset", offset, 14);
    ac = 0;

    // R10: no request, no strobe even with inputs toggling
    for (int k = 0; k < 4; k++) begin
      set_lv(7'(k * 37));
      @(negedge clk);
      chk("R10 idle", valid, 0);
      chk("R10 idle hold", offset, 14);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule